// File: doc/BRIEF.md
# Supply-Sense Write Lockout Controller

This block decides, cycle by cycle, whether the nonvolatile memory write controller may start a new write. It takes a digital supply-good level from an external comparator, passes it through a two-flop synchronizer, and keeps writes shut whenever that level is low. When the supply comes back, writes stay shut for a fixed hold-off. The hold-off is counted in ticks of a slow oscillator: 1000 ticks of a 5 kHz tick, or about 200 ms. Any dip during the hold-off clears the count, and the full delay starts again.

The block sits beside the memory write controller. That controller presents a write-start request. The block answers with a registered one-cycle grant, and only when writes are open. Reads never pass through this block, so they run freely during the hold-off. A write that has already started is never aborted here. Only new starts are refused. The comparator, its reference and the oscillator are outside the block; only their digital outputs arrive at its ports.

Top module: `supply_lockout_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, writeAllowed and writeGrant are 0 and the hold-off count is empty, so a full hold-off is needed even if supplyOk was high during reset.
- R2: supplyOk passes through two flip-flops before use. A fall of supplyOk driven before clock edge k leaves writeAllowed high after edge k and makes it low after edge k+1.
- R3: With the synchronized supply good and writes not yet open, each cycle with tickEn high adds one tick. writeAllowed goes to 1 at the edge that counts the HOLD_TICKS-th tick (default 1000). With tickEn high every cycle, a rise of supplyOk (or a reset release with supplyOk high) is followed by writeAllowed rising HOLD_TICKS+2 edges later.
- R4: If the synchronized supply goes low at any point during the hold-off, even for a single cycle, the count clears and the full HOLD_TICKS-tick hold-off restarts after recovery.
- R5: writeAllowed is 0 in every cycle in which the synchronized supply is low, with no extra cycle of lag, and a write request in such a cycle is refused.
- R6: writeGrant is 1 for exactly the cycle after an edge at which writeReq and writeAllowed were both 1, and 0 otherwise.
- R7: tickEn has no effect while the synchronized supply is low, and none once writes are open: ticks seen while locked do not shorten the hold-off, and writes stay open with no ticks at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle pulse per slow oscillator period |
| supplyOk | input | 1 | Asynchronous supply-good level from the comparator, 1 = above threshold |
| writeReq | input | 1 | Request to start a nonvolatile write |
| writeAllowed | output | 1 | 1 when a new write may start |
| writeGrant | output | 1 | Registered one-cycle grant of a write start |

## Verification
The bench measures the exact edge count from supply recovery to open writes, both after reset and after a long locked period full of ticks. A design that counted ticks while locked, or that missed a synchronizer stage, would open early or late by a visible number of edges. A single-cycle dip in the middle of the hold-off must restart the full count, and a design that only paused the counter would open about 500 edges too soon. On a supply fall, writeAllowed must drop the same cycle the synchronized level drops, and a design that waited for its state register would grant one stray write, which the grant check catches.

// File: rtl/lockout_pkg.sv
package lockout_pkg;

  typedef enum logic [1:0] {
    ST_LOCKED  = 2'd0,
    ST_HOLDOFF = 2'd1,
    ST_OPEN    = 2'd2
  } lockState_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic grantSet;
  } dpStrobe_t;

endpackage

// File: rtl/lockout_sync.sv
module lockout_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/lockout_datapath.sv
module lockout_datapath
  import lockout_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 1000,
  localparam int unsigned CNT_W = $clog2(HOLD_TICKS)
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobe,
  output logic      cntLast,
  output logic      grantQ
);

  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(HOLD_TICKS - 1);

  logic [CNT_W-1:0] holdCnt;

  // Hold-off tick counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (strobe.cntClear) begin
      holdCnt <= '0;
    end else if (strobe.cntInc) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  assign cntLast = (holdCnt == LAST_VAL);

  // Registered write-start grant
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) grantQ <= 1'b0;
    else       grantQ <= strobe.grantSet;
  end

endmodule

// File: rtl/lockout_ctrl.sv
module lockout_ctrl
  import lockout_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      supplySync,
  input  logic      tickEn,
  input  logic      writeReq,
  input  logic      cntLast,
  output dpStrobe_t strobe,
  output logic      writeAllowed
);

  lockState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_LOCKED;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext       = state;
    strobe.cntClear = 1'b0;
    strobe.cntInc   = 1'b0;
    if (!supplySync) begin
      // Any low level locks and clears, whatever the state
      stateNext       = ST_LOCKED;
      strobe.cntClear = 1'b1;
    end else begin
      unique case (state)
        ST_LOCKED, ST_HOLDOFF: begin
          stateNext = ST_HOLDOFF;
          if (tickEn) begin
            if (cntLast) begin
              stateNext       = ST_OPEN;
              strobe.cntClear = 1'b1;
            end else begin
              strobe.cntInc = 1'b1;
            end
          end
        end
        ST_OPEN: begin
          stateNext = ST_OPEN;
        end
        default: begin
          stateNext       = ST_LOCKED;
          strobe.cntClear = 1'b1;
        end
      endcase
    end
  end

  // Qualified by the synchronized level so a fall blocks writes at once
  assign writeAllowed    = (state == ST_OPEN) && supplySync;
  assign strobe.grantSet = writeReq && writeAllowed;

endmodule

// File: rtl/supply_lockout_ctrl.sv
module supply_lockout_ctrl #(
  parameter int unsigned HOLD_TICKS  = 1000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  logic supplyOk,
  input  logic writeReq,
  output logic writeAllowed,
  output logic writeGrant
);

  import lockout_pkg::*;

  logic      supplySync;
  logic      cntLast;
  dpStrobe_t strobe;

  lockout_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (supplyOk),
    .syncOut (supplySync)
  );

  lockout_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .supplySync   (supplySync),
    .tickEn       (tickEn),
    .writeReq     (writeReq),
    .cntLast      (cntLast),
    .strobe       (strobe),
    .writeAllowed (writeAllowed)
  );

  lockout_datapath #(.HOLD_TICKS(HOLD_TICKS)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cntLast (cntLast),
    .grantQ  (writeGrant)
  );

endmodule

// File: rtl/supply_lockout_ctrl_chk.sv
module supply_lockout_ctrl_chk #(
  parameter int unsigned HOLD_TICKS = 1000,
  localparam int unsigned TW = $clog2(HOLD_TICKS + 1)
) (
  input logic clk,
  input logic rstN,
  input logic tickEn,
  input logic supplyOk,
  input logic writeReq,
  input logic writeAllowed,
  input logic writeGrant,
  input logic supplySync
);

  // Ticks seen since the synchronized supply was last low, saturating
  logic [TW-1:0] tickSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              tickSeen <= '0;
    else if (!supplySync)                   tickSeen <= '0;
    else if (tickEn && tickSeen < TW'(HOLD_TICKS)) tickSeen <= tickSeen + 1'b1;
  end

  // R1: closed while in reset
  always @(posedge clk) begin
    if (!rstN) begin
      a_reset_closed_r1: assert (!writeAllowed && !writeGrant)
        else $error("writeAllowed/writeGrant high in reset");
    end
  end

  // R5: two sampled low levels at the input block writes on the next cycle
  p_low_blocks_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!supplyOk && $past(!supplyOk)) |=> !writeAllowed);

  // R4: writes open only after a full tick count since the last dip
  p_full_holdoff_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeAllowed) |-> (tickSeen >= TW'(HOLD_TICKS)));

  // R3: opening always happens on a tick edge
  p_open_on_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeAllowed) |-> $past(tickEn));

  // R6: grant only follows an allowed request
  p_grant_qualified_r6: assert property (@(posedge clk) disable iff (!rstN)
    writeGrant |-> $past(writeReq && writeAllowed));

  // R6: an allowed request always yields a grant
  p_grant_given_r6: assert property (@(posedge clk) disable iff (!rstN)
    (writeReq && writeAllowed) |=> writeGrant);

endmodule

bind supply_lockout_ctrl supply_lockout_ctrl_chk #(.HOLD_TICKS(HOLD_TICKS)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .tickEn       (tickEn),
  .supplyOk     (supplyOk),
  .writeReq     (writeReq),
  .writeAllowed (writeAllowed),
  .writeGrant   (writeGrant),
  .supplySync   (supplySync)
);

// File: tb/supply_lockout_ctrl_test.sv
module supply_lockout_ctrl_test;

  localparam int H = 1000;

  logic clk = 1'b0;
  logic rstN, tickEn, supplyOk, writeReq;
  logic writeAllowed, writeGrant;

  int nChecks = 0;
  int nFail   = 0;
  int tickMode = 1;   // 0 none, 1 every cycle, 2 random
  bit monOn = 1'b0;
  bit finished = 1'b0;

  supply_lockout_ctrl #(.HOLD_TICKS(H)) uut (
    .clk          (clk),
    .rstN         (rstN),
    .tickEn       (tickEn),
    .supplyOk     (supplyOk),
    .writeReq     (writeReq),
    .writeAllowed (writeAllowed),
    .writeGrant   (writeGrant)
  );

  always #10 clk = ~clk;

  task automatic check(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkInt(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model built from the requirements
  logic ms1, ms2, mOpen, mGrant;
  int   mCnt;

  function automatic logic expAllowed();
    return mOpen && ms2;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ms1 <= 1'b0; ms2 <= 1'b0; mOpen <= 1'b0; mGrant <= 1'b0; mCnt <= 0;
    end else begin
      ms1    <= supplyOk;
      ms2    <= ms1;
      mGrant <= writeReq && expAllowed();
      if (!ms2) begin
        mOpen <= 1'b0;
        mCnt  <= 0;
      end else if (!mOpen && tickEn) begin
        if (mCnt == H - 1) begin
          mOpen <= 1'b1;
          mCnt  <= 0;
        end else begin
          mCnt <= mCnt + 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    case (tickMode)
      0:       tickEn <= 1'b0;
      1:       tickEn <= 1'b1;
      default: tickEn <= ($urandom % 2) == 1;
    endcase
  end

  // Continuous comparison against the model
  always @(negedge clk) begin
    if (monOn && rstN && !finished) begin
      check(ms2 ? "R3 allowed vs model" : "R5 allowed vs model", writeAllowed, expAllowed());
      check("R6 grant vs model", writeGrant, mGrant);
    end
  end

  // Edges from now until writeAllowed is seen high
  task automatic measureRise(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!writeAllowed && n < 3 * H);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    rstN = 1'b0; supplyOk = 1'b1; writeReq = 1'b1; tickEn = 1'b0;
    repeat (3) @(negedge clk);
    // R1: closed in reset even with request and supply high
    check("R1 allowed in reset", writeAllowed, 1'b0);
    check("R1 grant in reset", writeGrant, 1'b0);
    writeReq = 1'b0;
    monOn = 1'b1;
    rstN = 1'b1;
    measureRise(n);
    // R1/R3: full hold-off after reset
    checkInt("R1 R3 edges reset to open", n, H + 2);

    // R6: grant one cycle after allowed request
    writeReq = 1'b1;
    @(negedge clk);
    check("R6 grant after request", writeGrant, 1'b1);
    writeReq = 1'b0;
    @(negedge clk);
    check("R6 grant single cycle", writeGrant, 1'b0);

    // R7: open stays open with no ticks
    tickMode = 0;
    repeat (50) @(negedge clk);
    check("R7 open without ticks", writeAllowed, 1'b1);

    // R2/R5: two-stage latency on a fall, then immediate block
    supplyOk = 1'b0;
    @(negedge clk);
    check("R2 still open one edge after fall", writeAllowed, 1'b1);
    @(negedge clk);
    check("R2 R5 closed two edges after fall", writeAllowed, 1'b0);
    writeReq = 1'b1;
    @(negedge clk);
    check("R5 request refused while low", writeGrant, 1'b0);
    writeReq = 1'b0;

    // R7: ticks while locked do not count
    tickMode = 1;
    repeat (2000) @(negedge clk);
    check("R7 locked during ticks", writeAllowed, 1'b0);
    supplyOk = 1'b1;
    measureRise(n);
    checkInt("R7 edges after locked ticks", n, H + 2);

    // R4: single-cycle dip mid hold-off restarts the count
    supplyOk = 1'b0;
    repeat (5) @(negedge clk);
    supplyOk = 1'b1;
    repeat (500) @(negedge clk);
    check("R4 closed mid hold-off", writeAllowed, 1'b0);
    supplyOk = 1'b0;
    @(negedge clk);
    supplyOk = 1'b1;
    measureRise(n);
    checkInt("R4 edges after dip", n, H + 2);

    // Random phase against the model
    tickMode = 2;
    for (int seg = 0; seg < 15; seg++) begin
      int len;
      bit good;
      len  = 200 + int'($urandom % 2800);
      good = ($urandom % 10) < 7;
      for (int i = 0; i < len; i++) begin
        @(negedge clk);
        supplyOk = good ? (($urandom % 400) != 0) : (($urandom % 200) == 0);
        writeReq = ($urandom % 4) == 0;
      end
    end
    writeReq = 1'b0;
    repeat (5) @(negedge clk);
    finish();
  end

endmodule